// File: doc/BRIEF.md
# Register Rename Map with Result Snooping

This block keeps the rename state of a small architectural register file in an out-of-order core. Each architectural register has one entry with a ready flag, the tag of the producer that will write it, and a committed or forwarded value. When an instruction is renamed, the two source registers are looked up. Each lookup returns either a usable value or the tag the consumer has to wait for. In the same cycle, the destination register is pointed at the scheduling slot that will produce its new value.

The table also watches the result broadcast bus. When a completed result carries the tag that a pending entry is waiting on, that entry takes the value and becomes ready. Only the most recent producer of a register can complete it. A result from an older producer that has since been superseded is dropped for that register, because a younger rename has already replaced the tag. A lookup that coincides with the matching broadcast is forwarded in the same cycle.

Top module: `rename_map_table`

## Requirements
- R1: After reset every entry is ready, and register i holds the value i*17 (0x00, 0x11, 0x22, ...).
- R2: A rename with `ren_valid` high makes the destination pending from the next cycle on, holding `ren_new_tag`; the value stored before is kept but not returned.
- R3: A lookup drives `srcN_ready`=1 with the value in `srcN_payload` when the entry is ready, and `srcN_ready`=0 with the tag zero-extended in the low TAG_W bits of `srcN_payload` when it is pending.
- R4: A broadcast (`bc_valid`=1) whose tag equals the tag of a pending entry makes that entry ready with `bc_value` from the next cycle; every pending entry holding that tag captures it.
- R5: A broadcast whose tag differs from a pending entry's tag leaves that entry unchanged, so after a second rename the older producer's result is dropped.
- R6: When a rename and a capturing broadcast hit the same register in one cycle, the rename wins and the entry stays pending with the new tag.
- R7: A lookup of a pending entry whose tag equals the broadcast tag in the same cycle returns ready with `bc_value` (bypass).
- R8: A source lookup in the cycle of a rename returns the mapping from before that rename, including when the source is the destination.
- R9: A ready entry ignores broadcasts, even one whose tag equals its stored tag.
- R10: The two lookup ports are independent: each returns the state of its own index in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ren_valid | input | 1 | Rename of the destination this cycle |
| ren_src0_idx | input | AREG_W | First source register index |
| ren_src1_idx | input | AREG_W | Second source register index |
| ren_dst_idx | input | AREG_W | Destination register index |
| ren_new_tag | input | TAG_W | Scheduling slot that will produce the destination |
| bc_valid | input | 1 | Result broadcast present |
| bc_tag | input | TAG_W | Tag of the broadcast result |
| bc_value | input | DATA_W | Broadcast result value |
| src0_ready | output | 1 | First source holds a value |
| src0_payload | output | DATA_W | Value or zero-extended tag of first source |
| src1_ready | output | 1 | Second source holds a value |
| src1_payload | output | DATA_W | Value or zero-extended tag of second source |

## Verification
After reset, every pair of source indices is swept on both ports. This shows that the initial values sit in the right entries and that the two ports do not interfere. The bench then runs the following patterns:
- A rename followed by a matching broadcast, which shows retagging and capture.
- A double rename of one register followed by a broadcast of the older tag, which shows that a stale producer is dropped.
- A broadcast that coincides with a rename of the register it matches, which shows rename priority.
- A lookup in the cycle of its matching broadcast, which shows the bypass.
- A lookup of the register being renamed, which shows pre-rename read ordering.
- Broadcasts aimed at ready entries, which show that ready state cannot be overwritten.

// File: rtl/rmt_pkg.sv
package rmt_pkg;

  // Value loaded into architectural register idx at reset.
  function automatic int unsigned rmt_reset_value(input int unsigned idx);
    return (idx << 4) + idx;
  endfunction

endpackage

// File: rtl/rmt_entry.sv
module rmt_entry #(
  parameter int TAG_W  = 3,
  parameter int DATA_W = 16,
  parameter logic [DATA_W-1:0] RST_VAL = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ren_hit,
  input  logic [TAG_W-1:0]  new_tag,
  input  logic              bc_valid,
  input  logic [TAG_W-1:0]  bc_tag,
  input  logic [DATA_W-1:0] bc_value,
  output logic              ent_valid,
  output logic [TAG_W-1:0]  ent_tag,
  output logic [DATA_W-1:0] ent_value,
  output logic              wake_hit
);

  logic tag_match;

  // Only a pending entry awaiting exactly this producer may capture.
  assign tag_match = bc_valid && !ent_valid && (ent_tag == bc_tag);
  // A same-cycle rename overrides the capture.
  assign wake_hit  = tag_match && !ren_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ent_valid <= 1'b1;
      ent_tag   <= '0;
      ent_value <= RST_VAL;
    end else if (ren_hit) begin
      ent_valid <= 1'b0;
      ent_tag   <= new_tag;
    end else if (wake_hit) begin
      ent_valid <= 1'b1;
      ent_value <= bc_value;
    end
  end

endmodule

// File: rtl/rmt_src_port.sv
module rmt_src_port #(
  parameter int NUM_REGS = 8,
  parameter int TAG_W    = 3,
  parameter int DATA_W   = 16,
  localparam int AREG_W  = $clog2(NUM_REGS)
) (
  input  logic [AREG_W-1:0]                   idx,
  input  logic [NUM_REGS-1:0]                 ent_valid,
  input  logic [NUM_REGS-1:0][TAG_W-1:0]      ent_tag,
  input  logic [NUM_REGS-1:0][DATA_W-1:0]     ent_value,
  input  logic                                bc_valid,
  input  logic [TAG_W-1:0]                    bc_tag,
  input  logic [DATA_W-1:0]                   bc_value,
  output logic                                ready,
  output logic [DATA_W-1:0]                   payload,
  output logic                                bypass_hit
);

  function automatic logic [DATA_W-1:0] widen_tag(input logic [TAG_W-1:0] t);
    logic [DATA_W-1:0] w;
    w = '0;
    w[TAG_W-1:0] = t;
    return w;
  endfunction

  logic              sel_valid;
  logic [TAG_W-1:0]  sel_tag;
  logic [DATA_W-1:0] sel_value;

  assign sel_valid  = ent_valid[idx];
  assign sel_tag    = ent_tag[idx];
  assign sel_value  = ent_value[idx];
  assign bypass_hit = !sel_valid && bc_valid && (sel_tag == bc_tag);

  always_comb begin
    if (sel_valid) begin
      ready   = 1'b1;
      payload = sel_value;
    end else if (bypass_hit) begin
      ready   = 1'b1;
      payload = bc_value;
    end else begin
      ready   = 1'b0;
      payload = widen_tag(sel_tag);
    end
  end

endmodule

// File: rtl/rename_map_table.sv
module rename_map_table #(
  parameter int NUM_REGS = 8,
  parameter int TAG_W    = 3,
  parameter int DATA_W   = 16,
  localparam int AREG_W  = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ren_valid,
  input  logic [AREG_W-1:0] ren_src0_idx,
  input  logic [AREG_W-1:0] ren_src1_idx,
  input  logic [AREG_W-1:0] ren_dst_idx,
  input  logic [TAG_W-1:0]  ren_new_tag,
  input  logic              bc_valid,
  input  logic [TAG_W-1:0]  bc_tag,
  input  logic [DATA_W-1:0] bc_value,
  output logic              src0_ready,
  output logic [DATA_W-1:0] src0_payload,
  output logic              src1_ready,
  output logic [DATA_W-1:0] src1_payload
);
  import rmt_pkg::*;

  localparam int NUM_SRC = 2;

  logic [NUM_REGS-1:0]             ent_valid;
  logic [NUM_REGS-1:0][TAG_W-1:0]  ent_tag;
  logic [NUM_REGS-1:0][DATA_W-1:0] ent_value;
  logic [NUM_REGS-1:0]             ren_hit;
  logic [NUM_REGS-1:0]             wake_hit;

  logic [NUM_SRC-1:0][AREG_W-1:0]  src_idx;
  logic [NUM_SRC-1:0]              src_ready;
  logic [NUM_SRC-1:0][DATA_W-1:0]  src_payload;
  logic [NUM_SRC-1:0]              src_bypass;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_REGS; gi++) begin : g_ent
      assign ren_hit[gi] = ren_valid && (ren_dst_idx == AREG_W'(gi));
      rmt_entry #(
        .TAG_W  (TAG_W),
        .DATA_W (DATA_W),
        .RST_VAL(DATA_W'(rmt_reset_value(gi)))
      ) u_entry (
        .clk      (clk),
        .rst_n    (rst_n),
        .ren_hit  (ren_hit[gi]),
        .new_tag  (ren_new_tag),
        .bc_valid (bc_valid),
        .bc_tag   (bc_tag),
        .bc_value (bc_value),
        .ent_valid(ent_valid[gi]),
        .ent_tag  (ent_tag[gi]),
        .ent_value(ent_value[gi]),
        .wake_hit (wake_hit[gi])
      );
    end
  endgenerate

  assign src_idx[0] = ren_src0_idx;
  assign src_idx[1] = ren_src1_idx;

  generate
    for (gi = 0; gi < NUM_SRC; gi++) begin : g_src
      rmt_src_port #(
        .NUM_REGS(NUM_REGS),
        .TAG_W   (TAG_W),
        .DATA_W  (DATA_W)
      ) u_src (
        .idx       (src_idx[gi]),
        .ent_valid (ent_valid),
        .ent_tag   (ent_tag),
        .ent_value (ent_value),
        .bc_valid  (bc_valid),
        .bc_tag    (bc_tag),
        .bc_value  (bc_value),
        .ready     (src_ready[gi]),
        .payload   (src_payload[gi]),
        .bypass_hit(src_bypass[gi])
      );
    end
  endgenerate

  assign src0_ready   = src_ready[0];
  assign src0_payload = src_payload[0];
  assign src1_ready   = src_ready[1];
  assign src1_payload = src_payload[1];

endmodule

// File: rtl/rmt_checker.sv
module rmt_checker #(
  parameter int NUM_REGS = 8,
  parameter int TAG_W    = 3,
  parameter int DATA_W   = 16,
  localparam int AREG_W  = $clog2(NUM_REGS)
) (
  input logic                             clk,
  input logic                             rst_n,
  input logic                             ren_valid,
  input logic [AREG_W-1:0]                ren_dst_idx,
  input logic [AREG_W-1:0]                ren_src0_idx,
  input logic [TAG_W-1:0]                 ren_new_tag,
  input logic                             bc_valid,
  input logic [TAG_W-1:0]                 bc_tag,
  input logic [DATA_W-1:0]                bc_value,
  input logic                             src0_ready,
  input logic [NUM_REGS-1:0]              ent_valid,
  input logic [NUM_REGS-1:0][TAG_W-1:0]   ent_tag,
  input logic [NUM_REGS-1:0][DATA_W-1:0]  ent_value,
  input logic [NUM_REGS-1:0]              wake_hit
);

  p_reset_ready_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (&ent_valid));

  p_rename_pending_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ren_valid |=> (!ent_valid[$past(ren_dst_idx)] &&
                   ent_tag[$past(ren_dst_idx)] == $past(ren_new_tag)));

  // R3: a not-ready lookup only occurs on a pending entry.
  p_lookup_pending_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !src0_ready |-> !ent_valid[ren_src0_idx]);

  p_rename_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ren_valid && bc_valid && !ent_valid[ren_dst_idx] &&
     ent_tag[ren_dst_idx] == bc_tag) |=> !ent_valid[$past(ren_dst_idx)]);

  // R7: a pending source whose tag is on the bus reads as ready.
  p_bypass_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bc_valid && !ent_valid[ren_src0_idx] && ent_tag[ren_src0_idx] == bc_tag)
      |-> src0_ready);

  genvar gi;
  generate
    for (gi = 0; gi < NUM_REGS; gi++) begin : g_chk
      p_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wake_hit[gi] |=> (ent_valid[gi] && ent_value[gi] == $past(bc_value)));

      p_stale_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!ent_valid[gi] && !(bc_valid && ent_tag[gi] == bc_tag) &&
         !(ren_valid && ren_dst_idx == AREG_W'(gi))) |=> !ent_valid[gi]);

      p_ready_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ent_valid[gi] && !(ren_valid && ren_dst_idx == AREG_W'(gi)))
          |=> (ent_valid[gi] && $stable(ent_value[gi])));
    end
  endgenerate

endmodule

bind rename_map_table rmt_checker #(
  .NUM_REGS(NUM_REGS),
  .TAG_W   (TAG_W),
  .DATA_W  (DATA_W)
) u_rmt_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .ren_valid   (ren_valid),
  .ren_dst_idx (ren_dst_idx),
  .ren_src0_idx(ren_src0_idx),
  .ren_new_tag (ren_new_tag),
  .bc_valid    (bc_valid),
  .bc_tag      (bc_tag),
  .bc_value    (bc_value),
  .src0_ready  (src0_ready),
  .ent_valid   (ent_valid),
  .ent_tag     (ent_tag),
  .ent_value   (ent_value),
  .wake_hit    (wake_hit)
);

// File: tb/rename_map_table_tb_top.sv
module rename_map_table_tb_top;

  localparam int NREG = 8;
  localparam int TW   = 3;
  localparam int DW   = 16;
  localparam int AW   = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ren_valid = 1'b0;
  logic [AW-1:0] ren_src0_idx = '0;
  logic [AW-1:0] ren_src1_idx = '0;
  logic [AW-1:0] ren_dst_idx = '0;
  logic [TW-1:0] ren_new_tag = '0;
  logic          bc_valid = 1'b0;
  logic [TW-1:0] bc_tag = '0;
  logic [DW-1:0] bc_value = '0;
  logic          src0_ready;
  logic [DW-1:0] src0_payload;
  logic          src1_ready;
  logic [DW-1:0] src1_payload;

  int tests = 0;
  int fails = 0;

  // Reference state, kept from the requirements.
  bit ref_rdy [NREG];
  int ref_tag [NREG];
  int ref_val [NREG];

  always #10 clk = ~clk;

  rename_map_table dut_i (
    .clk(clk), .rst_n(rst_n),
    .ren_valid(ren_valid), .ren_src0_idx(ren_src0_idx), .ren_src1_idx(ren_src1_idx),
    .ren_dst_idx(ren_dst_idx), .ren_new_tag(ren_new_tag),
    .bc_valid(bc_valid), .bc_tag(bc_tag), .bc_value(bc_value),
    .src0_ready(src0_ready), .src0_payload(src0_payload),
    .src1_ready(src1_ready), .src1_payload(src1_payload)
  );

  task automatic check(input string req, input int act, input int exp, input string what);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic expect_src(input string req, input int idx, input bit rdy, input int pay, input int port);
    if (port == 0) begin
      check(req, int'(src0_ready), int'(rdy), $sformatf("src0[%0d] ready", idx));
      check(req, int'(src0_payload), pay, $sformatf("src0[%0d] payload", idx));
    end else begin
      check(req, int'(src1_ready), int'(rdy), $sformatf("src1[%0d] ready", idx));
      check(req, int'(src1_payload), pay, $sformatf("src1[%0d] payload", idx));
    end
  endtask

  // One cycle: drive, check lookups against reference, clock, update reference.
  task automatic step(input string req, input bit rv, input int s0, input int s1, input int d,
                      input int t, input bit bv, input int bt, input int bval);
    bit e_rdy;
    int e_pay;
    @(negedge clk);
    ren_valid = rv; ren_src0_idx = AW'(s0); ren_src1_idx = AW'(s1);
    ren_dst_idx = AW'(d); ren_new_tag = TW'(t);
    bc_valid = bv; bc_tag = TW'(bt); bc_value = DW'(bval);
    #5;
    for (int p = 0; p < 2; p++) begin
      int s;
      s = (p == 0) ? s0 : s1;
      if (ref_rdy[s]) begin e_rdy = 1; e_pay = ref_val[s]; end
      else if (bv && ref_tag[s] == bt) begin e_rdy = 1; e_pay = bval; end
      else begin e_rdy = 0; e_pay = ref_tag[s]; end
      expect_src(req, s, e_rdy, e_pay, p);
    end
    @(posedge clk);
    #1;
    for (int i = 0; i < NREG; i++) begin
      if (rv && d == i) begin ref_rdy[i] = 0; ref_tag[i] = t; end
      else if (bv && !ref_rdy[i] && ref_tag[i] == bt) begin ref_rdy[i] = 1; ref_val[i] = bval; end
    end
  endtask

  task automatic look(input string req, input int s0, input int s1);
    step(req, 0, s0, s1, 0, 0, 0, 0, 0);
  endtask

  initial begin
    for (int i = 0; i < NREG; i++) begin
      ref_rdy[i] = 1; ref_tag[i] = 0; ref_val[i] = i * 17;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 / R10: full sweep of index pairs after reset.
    for (int a = 0; a < NREG; a++)
      for (int b = 0; b < NREG; b++)
        look("R1", a, b);

    // R8: rename r4 while reading r4 on both ports -> old value.
    step("R8", 1, 4, 4, 4, 2, 0, 0, 0);
    // R2 / R3: r4 now pending with tag 2.
    look("R2", 4, 3);
    check("R3", int'(src0_payload), 2, "pending payload is tag");

    // R4: rename r3 tag 5, then capture.
    step("R2", 1, 3, 0, 3, 5, 0, 0, 0);
    step("R4", 0, 3, 4, 0, 0, 1, 5, 'h1234);
    look("R4", 3, 4);

    // R4: two registers sharing one tag both capture.
    step("R2", 1, 1, 2, 1, 6, 0, 0, 0);
    step("R2", 1, 1, 2, 2, 6, 0, 0, 0);
    look("R3", 1, 2);
    step("R4", 0, 0, 0, 0, 0, 1, 6, 'h0abc);
    look("R4", 1, 2);

    // R5: double rename, stale broadcast dropped.
    step("R2", 1, 5, 5, 5, 1, 0, 0, 0);
    step("R2", 1, 5, 5, 5, 7, 0, 0, 0);
    step("R5", 0, 0, 0, 0, 0, 1, 1, 'hbeef);
    look("R5", 5, 0);
    step("R4", 0, 0, 0, 0, 0, 1, 7, 'h7777);
    look("R5", 5, 5);

    // R6: rename and capture collide on r6.
    step("R2", 1, 6, 6, 6, 3, 0, 0, 0);
    step("R6", 1, 6, 7, 6, 4, 1, 3, 'h3333);
    look("R6", 6, 7);

    // R7: r4 pending on tag 2, bypass in broadcast cycle.
    step("R7", 0, 4, 6, 0, 0, 1, 2, 'h0055);
    look("R7", 4, 6);

    // R9: ready r7 (stored tag 0) and r0 ignore a broadcast of tag 0.
    step("R9", 0, 7, 0, 0, 0, 1, 0, 'haaaa);
    look("R9", 7, 0);
    // R9: r3 captured tag 5 earlier; broadcast tag 5 again.
    step("R9", 0, 3, 1, 0, 0, 1, 5, 'hffff);
    look("R9", 3, 1);

    // R10: ports read different states simultaneously.
    step("R10", 1, 0, 0, 0, 4, 0, 0, 0);
    look("R10", 0, 2);
    look("R10", 2, 0);
    step("R10", 0, 6, 0, 0, 0, 1, 4, 'h4444);
    look("R10", 6, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(20 * 200000);
    fails++;
    tests++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule